// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of an event timer. It watches a free-running 64-bit main counter that is shared with other channels. When the counter reaches the value programmed into its comparator, it raises a one-cycle interrupt request pulse. Next to that pulse it presents a 5-bit routing field, which tells the interrupt fabric where the request should go.

Software controls the channel through a 32-bit register port, selected by a 2-bit word offset.

- In one-shot mode the channel fires once.
- In periodic mode a hidden period register advances the comparator after every match.
- A set-value control bit lets software load the comparator directly while the channel is periodic.
- A 32-bit mode makes the channel compare and add on the low 32 bits only.
- In 32-bit mode, a one-shot channel also fires when the low counter word rolls over.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the configuration reads 0x0000_0030 at offset 0 and 0x0000_0C20 at offset 1, the comparator reads all ones at offsets 2 and 3, the hidden period is zero, and irq_o is low.
- R2: A write to offset 0 changes only configuration bits 1, 2, 3, 6, 8 and 9 to 13 (mask 0x3F4E); the other bits keep their value. Writes to offset 1 are ignored. route_o always shows configuration bits 13:9.
- R3: A write to offset 0 with data bit 8 set (32-bit mode) clears the upper 32 bits of both the comparator and the period.
- R4: Offset 2 addresses the low half and offset 3 the high half of the comparator. A write there replaces that half of the comparator when bit 3 (periodic) is clear or bit 6 (set-value) is set; otherwise it replaces the same half of the hidden period.
- R5: Every write to offset 2 or 3 clears configuration bit 6 (set-value).
- R6: A value written into the period has its top bit cleared: bit 31 of a low-half write in 32-bit mode, and bit 63 for a high-half write.
- R7: The channel fires when the signed difference (counter minus comparator) changes from negative to non-negative. It gives exactly one irq_o pulse, one clock after the edge at which the counter value is sampled.
- R8: In periodic mode with a non-zero period, the comparator is increased by the period on each clock where the counter is not behind it, until it is ahead again. A catch-up that takes several clocks still yields a single pulse.
- R9: In 32-bit mode the difference is a signed 32-bit value over the low words, and the periodic sum wraps modulo 2^32 with the upper comparator word held at zero.
- R10: A one-shot channel in 32-bit mode also pulses when the low 32 bits of the counter go from all ones to zero, in addition to its comparator match.
- R11: Pulses and periodic advances occur only when configuration bit 2 (channel enable) and glb_en_i are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_off_i | input | 2 | Word offset for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered, valid one clock after the offset |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| route_o | output | 5 | Interrupt routing field |

## Verification
The checker watches the following rules on every clock:

- a pulse never appears unless both enables were set;
- any comparator write leaves set-value clear;
- writes to the upper configuration word change nothing;
- a 32-bit mode write leaves the upper comparator and period words at zero;
- a written period never has its top bit set;
- reset loads the comparator and period.

Only the bench scenarios can show the following, by comparing pulse times against counter values kept in a scoreboard:

- which counter value causes a pulse;
- that a periodic channel re-arms at the next multiple of its period;
- that a catch-up after a counter jump yields one pulse;
- that the 32-bit sum wraps correctly;
- that the rollover pulse appears only for a one-shot channel.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  // register word offsets
  localparam logic [1:0] OFF_CFG_LO = 2'd0;
  localparam logic [1:0] OFF_CFG_HI = 2'd1;
  localparam logic [1:0] OFF_CMP_LO = 2'd2;
  localparam logic [1:0] OFF_CMP_HI = 2'd3;

  // configuration bit positions
  localparam int B_EN    = 2;
  localparam int B_PER   = 3;
  localparam int B_PCAP  = 4;
  localparam int B_WCAP  = 5;
  localparam int B_SETV  = 6;
  localparam int B_W32   = 8;
  localparam int B_RT_LO = 9;
  localparam int RT_W    = 5;

  localparam logic [31:0] CFG_WMASK = 32'h0000_3F4E;
  localparam logic [63:0] CFG_RST   = 64'h0000_0C20_0000_0030;
endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
  import evt_cmp_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_off_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          adv_i,
  output logic [CW-1:0] cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] per_o
);
  localparam logic [DW-1:0] WMASK = CFG_WMASK[DW-1:0];
  localparam logic [CW-1:0] RSTV  = CFG_RST[CW-1:0];

  logic [CW-1:0] cfg_q, cmp_q, per_q;
  logic          mode32, to_cmp;
  logic [DW-1:0] per_lo_wr, per_hi_wr, cmp_sum32;

  assign mode32    = cfg_q[B_W32];
  assign to_cmp    = !cfg_q[B_PER] || cfg_q[B_SETV];
  assign per_lo_wr = mode32 ? {1'b0, wr_data_i[DW-2:0]} : wr_data_i;
  assign per_hi_wr = {1'b0, wr_data_i[DW-2:0]};
  assign cmp_sum32 = cmp_q[DW-1:0] + per_q[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RSTV;
      cmp_q <= '1;
      per_q <= '0;
    end else if (wr_en_i) begin
      case (wr_off_i)
        OFF_CFG_LO: begin
          cfg_q[DW-1:0] <= (wr_data_i & WMASK) | (cfg_q[DW-1:0] & ~WMASK);
          if (wr_data_i[B_W32]) begin
            cmp_q[CW-1:DW] <= '0;
            per_q[CW-1:DW] <= '0;
          end
        end
        OFF_CMP_LO: begin
          if (to_cmp) cmp_q[DW-1:0] <= wr_data_i;
          else        per_q[DW-1:0] <= per_lo_wr;
          cfg_q[B_SETV] <= 1'b0;
        end
        OFF_CMP_HI: begin
          if (to_cmp) cmp_q[CW-1:DW] <= wr_data_i;
          else        per_q[CW-1:DW] <= per_hi_wr;
          cfg_q[B_SETV] <= 1'b0;
        end
        default: ;
      endcase
    end else if (adv_i) begin
      if (mode32) cmp_q <= {{DW{1'b0}}, cmp_sum32};
      else        cmp_q <= cmp_q + per_q;
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
  assign per_o = per_q;
endmodule

// File: rtl/evt_cmp_detect.sv
module evt_cmp_detect #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [CW-1:0] per_i,
  input  logic          ch_en_i,
  input  logic          periodic_i,
  input  logic          mode32_i,
  input  logic          glb_en_i,
  output logic          adv_o,
  output logic          irq_o
);
  logic [CW-1:0] diff_w;
  logic [DW-1:0] diff_n;
  logic          armed, ge, per_nz, hit, wrap;
  logic          ge_q, lo_ones_q, irq_q;

  assign diff_w = cnt_i - cmp_i;
  assign diff_n = cnt_i[DW-1:0] - cmp_i[DW-1:0];
  assign ge     = mode32_i ? !diff_n[DW-1] : !diff_w[CW-1];
  assign per_nz = mode32_i ? (|per_i[DW-1:0]) : (|per_i);
  assign armed  = ch_en_i && glb_en_i;
  assign adv_o  = armed && periodic_i && per_nz && ge;
  assign hit    = ge && !ge_q;
  assign wrap   = mode32_i && !periodic_i && lo_ones_q && (cnt_i[DW-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_q      <= 1'b1;
      lo_ones_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      ge_q      <= ge;
      lo_ones_q <= &cnt_i[DW-1:0];
      irq_q     <= armed && (hit || wrap);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   cnt_i,
  input  logic            glb_en_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_off_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_o,
  output logic [RT_W-1:0] route_o
);
  logic [CW-1:0] cfg_q, cmp_q, per_q;
  logic          adv;
  logic [DW-1:0] rdata_q;

  evt_cmp_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (reg_wr_i),
    .wr_off_i  (reg_off_i),
    .wr_data_i (reg_wdata_i),
    .adv_i     (adv),
    .cfg_o     (cfg_q),
    .cmp_o     (cmp_q),
    .per_o     (per_q)
  );

  evt_cmp_detect #(.DW(DW)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .cnt_i      (cnt_i),
    .cmp_i      (cmp_q),
    .per_i      (per_q),
    .ch_en_i    (cfg_q[B_EN]),
    .periodic_i (cfg_q[B_PER]),
    .mode32_i   (cfg_q[B_W32]),
    .glb_en_i   (glb_en_i),
    .adv_o      (adv),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_off_i)
        OFF_CFG_LO: rdata_q <= cfg_q[DW-1:0];
        OFF_CFG_HI: rdata_q <= cfg_q[CW-1:DW];
        OFF_CMP_LO: rdata_q <= cmp_q[DW-1:0];
        default:    rdata_q <= cmp_q[CW-1:DW];
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
  assign route_o     = cfg_q[B_RT_LO +: RT_W];
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          glb_en_i,
  input logic          reg_wr_i,
  input logic [1:0]    reg_off_i,
  input logic          wr_w32_i,
  input logic          irq_o,
  input logic [CW-1:0] cfg_q,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] per_q
);
  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> (cmp_q == '1 && per_q == '0 && !irq_o));

  p_hi_cfg_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_off_i == 2'd1) |=> $stable(cfg_q));

  p_trunc_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_off_i == 2'd0 && wr_w32_i) |=>
      (cmp_q[CW-1:DW] == '0 && per_q[CW-1:DW] == '0));

  p_setval_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_off_i[1]) |=> !cfg_q[6]);

  p_period_top_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_off_i == 2'd3 && cfg_q[3] && !cfg_q[6]) |=> !per_q[CW-1]);

  p_period_top_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_off_i == 2'd2 && cfg_q[3] && !cfg_q[6] && cfg_q[8])
      |=> !per_q[DW-1]);

  p_gated_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(cfg_q[2] && glb_en_i));
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .glb_en_i  (glb_en_i),
  .reg_wr_i  (reg_wr_i),
  .reg_off_i (reg_off_i),
  .wr_w32_i  (reg_wdata_i[evt_cmp_pkg::B_W32]),
  .irq_o     (irq_o),
  .cfg_q     (cfg_q),
  .cmp_q     (cmp_q),
  .per_q     (per_q)
);

// File: tb/evt_cmp_channel_tb.sv
`timescale 1ns/100ps
module evt_cmp_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt = '0;
  logic        run = 1'b0;
  logic        glb_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_off = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [4:0]  route;

  int n_chk = 0;
  int n_err = 0;
  int n_unexp = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  evt_cmp_channel u_dut (
    .clk(clk), .rst(rst), .cnt_i(cnt), .glb_en_i(glb_en),
    .reg_wr_i(reg_wr), .reg_off_i(reg_off), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .route_o(route)
  );

  always @(negedge clk) if (run) cnt <= cnt + 64'd1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: each pulse pops the counter value it is expected at
  initial forever begin
    @(posedge clk); #1;
    if (!rst && irq) begin
      if (exp_q.size() == 0) begin
        n_unexp++;
        n_chk++; n_err++;
        $display("FAIL R7/R11 unexpected pulse actual=%h expected=none", cnt);
      end else begin
        automatic logic [63:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, cnt, e);
      end
    end
  end

  task automatic expect_pulse(input logic [63:0] at, input string tag);
    exp_q.push_back(at);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] off, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] off, output logic [31:0] d);
    @(posedge clk); #2;
    reg_off = off;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    @(posedge clk); #2;
    cnt = v;
  endtask

  task automatic run_n(input int n);
    @(posedge clk); #2;
    run = 1'b1;
    repeat (n) @(posedge clk);
    #2 run = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drained(input string tag);
    chk(tag, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1 reset state
    rd(2'd0, d); chk("R1 cfg lo", d, 32'h0000_0030);
    rd(2'd1, d); chk("R1 cfg hi", d, 32'h0000_0C20);
    rd(2'd2, d); chk("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R1 cmp hi", d, 32'hFFFF_FFFF);
    chk("R1 irq low", irq, 1'b0);

    // R2 writable mask, route field; R3 truncation on 32-bit mode write
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 cfg mask", d, 32'h0000_3F7E);
    chk("R2 route", route, 5'h1F);
    rd(2'd3, d); chk("R3 cmp upper cleared", d, 32'h0);
    rd(2'd2, d); chk("R3 cmp lower kept", d, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R2 cfg hi ignored", d, 32'h0000_0C20);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R2 caps kept", d, 32'h0000_0030);

    // R7 one-shot 64-bit match
    set_cnt(64'd50);
    wr(2'd2, 32'd100);
    wr(2'd3, 32'd0);
    glb_en = 1'b1;
    wr(2'd0, 32'h0000_0004);
    expect_pulse(64'd100, "R7 one-shot match");
    run_n(60);
    drained("R7 one pulse only");

    // R11 gating by global and channel enable
    @(posedge clk); #2 glb_en = 1'b0;
    wr(2'd2, 32'd130);
    run_n(20);
    @(posedge clk); #2 glb_en = 1'b1;
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd160);
    run_n(20);
    idle(3);
    chk("R11 no gated pulse", 64'(n_unexp), 64'd0);

    // R4/R5 periodic programming via set-value, R8 advance
    wr(2'd0, 32'h0000_0048);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h0000_0048);
    wr(2'd2, 32'd200);
    wr(2'd2, 32'd50);
    wr(2'd3, 32'd0);
    rd(2'd0, d); chk("R5 set-value cleared", d, 32'h0000_0038);
    rd(2'd2, d); chk("R4 period write keeps cmp", d, 32'd200);
    set_cnt(64'd150);
    wr(2'd0, 32'h0000_000C);
    expect_pulse(64'd200, "R8 first periodic");
    expect_pulse(64'd250, "R8 second periodic");
    expect_pulse(64'd300, "R8 third periodic");
    run_n(170);
    idle(2);
    drained("R8 periodic pulses");
    rd(2'd2, d); chk("R8 cmp advanced", d, 32'd350);
    expect_pulse(64'd1000, "R8 catch-up single pulse");
    set_cnt(64'd1000);
    idle(20);
    drained("R8 catch-up");
    rd(2'd2, d); chk("R8 cmp after catch-up", d, 32'd1050);

    // R9 32-bit periodic wrap, R6 period top bit cleared
    wr(2'd0, 32'h0000_0148);
    set_cnt(64'h0000_0000_FFFF_FFE0);
    wr(2'd2, 32'hFFFF_FFF0);
    wr(2'd2, 32'h8000_0020);
    wr(2'd0, 32'h0000_010C);
    expect_pulse(64'h0000_0000_FFFF_FFF0, "R9 32-bit match");
    expect_pulse(64'h0000_0001_0000_0010, "R6/R9 wrapped sum, no rollover pulse");
    run_n(56);
    idle(2);
    drained("R9 periodic 32-bit");
    rd(2'd2, d); chk("R9 cmp lo wrapped", d, 32'h0000_0030);
    rd(2'd3, d); chk("R9 cmp hi zero", d, 32'h0);

    // R10 one-shot 32-bit rollover pulse plus match
    wr(2'd0, 32'h0000_0100);
    set_cnt(64'h0000_0001_FFFF_FFF8);
    wr(2'd2, 32'h0000_0008);
    wr(2'd0, 32'h0000_0104);
    expect_pulse(64'h0000_0002_0000_0000, "R10 rollover pulse");
    expect_pulse(64'h0000_0002_0000_0008, "R10 match after rollover");
    run_n(20);
    idle(2);
    drained("R10 both pulses");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule